// File: doc/BRIEF.md
# Gshare Direction Predictor with Mispredict Fetch Stall

This block predicts the direction of conditional branches at fetch time and controls fetch after a branch that will be mispredicted. A pattern table of two-bit saturating counters is indexed by combining the fetch PC with a global history of resolved branch outcomes. The index used for each lookup is saved in a small pending list, so the counter that made a prediction is also the one trained at resolution, even after the history has moved on.

When a conditional branch is known to be mispredicted, the front end sets a flag with the fetch. From the next cycle the block holds fetch stalled, and no wrong-path work enters the pipeline. Restart takes a fixed two steps. In the cycle after the branch resolves, the block presents the corrected PC on a redirect port while fetch is still held. In the cycle after that, fetch resumes on the correct path.

Top module: `gshare_fetch_ctl`

## Requirements
- R1: The table holds 2^HIST_LEN two-bit counters. A lookup uses index fetch_pc[HIST_LEN+1:2] XOR history and predicts taken when the counter is 2 or 3 (counter bit 1 set).
- R2: After reset every counter is 1 (weakly not-taken), the history is zero, fetch_stall and redirect_valid are low, and every lookup predicts not-taken.
- R3: Only a fetch with fetch_is_cbr high performs a lookup. Otherwise pred_taken is 0 and nothing is recorded.
- R4: At resolution the counter counts up on taken and down on not-taken. It saturates at 3 and at 0 and does not wrap.
- R5: At each resolution the history shifts left by one, and the actual outcome enters bit 0.
- R6: Resolutions arrive in fetch order. Each one trains the entry saved at its own lookup. A res_valid with no pending branch is ignored and leaves the history unchanged.
- R7: After an accepted lookup with fetch_mispred high, fetch_stall is high from the next cycle until that branch resolves.
- R8: In the cycle after the mispredicted branch resolves, redirect_valid is 1 and fetch_stall stays 1. redirect_pc is res_target if the branch was taken, and res_pc + 4 if it was not.
- R9: In the cycle after the redirect, fetch_stall and redirect_valid are both 0.
- R10: While a mispredict stall is pending, lookups are ignored: pred_taken is 0 and nothing is recorded.
- R11: The pending list holds PEND_DEPTH branches. While it is full, fetch_stall is high and lookups are ignored. It clears once a resolution frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC of the instruction being fetched |
| fetch_is_cbr | input | 1 | Instruction is a conditional branch |
| fetch_mispred | input | 1 | This conditional branch will be mispredicted |
| pred_taken | output | 1 | Predicted direction for the current lookup |
| fetch_stall | output | 1 | Fetch must not advance this cycle |
| res_valid | input | 1 | A conditional branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_target | input | PC_W | Taken target of the resolving branch |
| redirect_valid | output | 1 | redirect_pc must be loaded into the PC latch |
| redirect_pc | output | PC_W | Correct-path restart address |

## Verification
The bench builds the block with HIST_LEN = 4 and PEND_DEPTH = 4. A 16-entry table lets a few hand-picked PCs force many lookups onto the same counter under different histories, which makes saturation at both ends and index retention directly visible in pred_taken. A four-deep pending list fills after four unresolved branches, so the full-list stall and its release are reached in a handful of cycles. Both redirect directions are exercised, and the ignored cases are checked through later predictions.

// File: rtl/gsf_pkg.sv
package gsf_pkg;

    typedef enum logic [1:0] {
        FS_RUN   = 2'd0,
        FS_HOLD  = 2'd1,
        FS_REDIR = 2'd2
    } fs_state_e;

    localparam logic [1:0] CTR_INIT = 2'd1;

    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        logic [1:0] nxt;
        if (up) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
        else    nxt = (cur == 2'd0) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/gsf_pht.sv
module gsf_pht #(
    parameter int HIST_LEN = 8,
    parameter int PC_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PC_W-1:0]     lk_pc,
    output logic [HIST_LEN-1:0] lk_idx,
    output logic                lk_taken,
    input  logic                up_en,
    input  logic [HIST_LEN-1:0] up_idx,
    input  logic                up_taken
);
    import gsf_pkg::*;

    localparam int ENTRIES = 1 << HIST_LEN;

    typedef struct packed {
        logic [HIST_LEN-1:0]      hist;
        logic [ENTRIES-1:0][1:0]  ctr;
    } pht_s;

    pht_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (up_en) begin
            st_d.ctr[up_idx] = ctr_step(st_q.ctr[up_idx], up_taken);
            if (HIST_LEN > 1) st_d.hist = {st_q.hist[HIST_LEN-2:0], up_taken};
            else              st_d.hist = HIST_LEN'(up_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist <= '0;
            st_q.ctr  <= {ENTRIES{CTR_INIT}};
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_idx   = lk_pc[HIST_LEN+1:2] ^ st_q.hist;
    assign lk_taken = st_q.ctr[lk_idx][1];

endmodule

// File: rtl/gsf_pend_fifo.sv
module gsf_pend_fifo #(
    parameter int IDX_W = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             push_mp,
    input  logic             pop,
    output logic             empty,
    output logic             full,
    output logic [IDX_W-1:0] head_idx,
    output logic             head_mp
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W:0] slot;
        logic [PTR_W-1:0]          wr;
        logic [PTR_W-1:0]          rd;
        logic [PTR_W:0]            cnt;
    } fifo_s;

    fifo_s st_d, st_q;
    logic  do_push, do_pop;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == (PTR_W+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.slot[st_q.wr] = {push_mp, push_idx};
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_idx = st_q.slot[st_q.rd][IDX_W-1:0];
    assign head_mp  = st_q.slot[st_q.rd][IDX_W];

endmodule

// File: rtl/gsf_stall_fsm.sv
module gsf_stall_fsm #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mp_accept,
    input  logic            res_fire,
    input  logic            res_is_mp,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_pc,
    input  logic [PC_W-1:0] res_target,
    output logic            hold,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    import gsf_pkg::*;

    typedef struct packed {
        fs_state_e       state;
        logic [PC_W-1:0] rpc;
    } fsm_s;

    fsm_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            FS_RUN: begin
                if (mp_accept) st_d.state = FS_HOLD;
            end
            FS_HOLD: begin
                if (res_fire && res_is_mp) begin
                    st_d.state = FS_REDIR;
                    st_d.rpc   = res_taken ? res_target : res_pc + PC_W'(4);
                end
            end
            FS_REDIR: st_d.state = FS_RUN;
            default:  st_d.state = FS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= FS_RUN;
            st_q.rpc   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold           = (st_q.state != FS_RUN);
    assign redirect_valid = (st_q.state == FS_REDIR);
    assign redirect_pc    = st_q.rpc;

endmodule

// File: rtl/gshare_fetch_ctl.sv
module gshare_fetch_ctl #(
    parameter int HIST_LEN   = 8,
    parameter int PC_W       = 32,
    parameter int PEND_DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            fetch_is_cbr,
    input  logic            fetch_mispred,
    output logic            pred_taken,
    output logic            fetch_stall,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    logic [HIST_LEN-1:0] lk_idx, head_idx;
    logic                lk_taken, head_mp;
    logic                q_empty, q_full, hold;
    logic                accept, res_fire;

    assign accept   = fetch_is_cbr && !hold && !q_full;
    assign res_fire = res_valid && !q_empty;

    gsf_pht #(.HIST_LEN(HIST_LEN), .PC_W(PC_W)) pht_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (fetch_pc),
        .lk_idx   (lk_idx),
        .lk_taken (lk_taken),
        .up_en    (res_fire),
        .up_idx   (head_idx),
        .up_taken (res_taken)
    );

    gsf_pend_fifo #(.IDX_W(HIST_LEN), .DEPTH(PEND_DEPTH)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_idx (lk_idx),
        .push_mp  (fetch_mispred),
        .pop      (res_fire),
        .empty    (q_empty),
        .full     (q_full),
        .head_idx (head_idx),
        .head_mp  (head_mp)
    );

    gsf_stall_fsm #(.PC_W(PC_W)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mp_accept      (accept && fetch_mispred),
        .res_fire       (res_fire),
        .res_is_mp      (head_mp),
        .res_taken      (res_taken),
        .res_pc         (res_pc),
        .res_target     (res_target),
        .hold           (hold),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    assign pred_taken  = accept && lk_taken;
    assign fetch_stall = hold || q_full;

endmodule

// File: rtl/gshare_fetch_ctl_chk.sv
module gshare_fetch_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic fetch_is_cbr,
    input logic fetch_mispred,
    input logic pred_taken,
    input logic fetch_stall,
    input logic res_valid,
    input logic redirect_valid
);
    p_pred_only_cbr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_is_cbr |-> !pred_taken);

    p_no_pred_in_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> !pred_taken);

    p_mispred_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_is_cbr && fetch_mispred && !fetch_stall) |=> fetch_stall);

    p_redirect_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> fetch_stall);

    p_redirect_follows_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect_valid) |-> $past(res_valid));

    p_restart_after_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (!fetch_stall && !redirect_valid));
endmodule

bind gshare_fetch_ctl gshare_fetch_ctl_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_is_cbr   (fetch_is_cbr),
    .fetch_mispred  (fetch_mispred),
    .pred_taken     (pred_taken),
    .fetch_stall    (fetch_stall),
    .res_valid      (res_valid),
    .redirect_valid (redirect_valid)
);

// File: tb/gshare_fetch_ctl_tb_top.sv
module gshare_fetch_ctl_tb_top;
    localparam int HL = 4;
    localparam int PW = 32;
    localparam int PD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] fetch_pc = '0;
    logic          fetch_is_cbr = 1'b0;
    logic          fetch_mispred = 1'b0;
    logic          pred_taken, fetch_stall;
    logic          res_valid = 1'b0;
    logic [PW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic [PW-1:0] res_target = '0;
    logic          redirect_valid;
    logic [PW-1:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gshare_fetch_ctl #(.HIST_LEN(HL), .PC_W(PW), .PEND_DEPTH(PD)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_is_cbr(fetch_is_cbr),
        .fetch_mispred(fetch_mispred), .pred_taken(pred_taken), .fetch_stall(fetch_stall),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    typedef struct packed {
        logic        cbr;
        logic [31:0] pc;
        logic        rv;
        logic        rt;
        logic        exp_pred;
    } vec_t;

    // Scenario on counter 4 (history starts at 0); tags R1 R4 R5
    localparam vec_t VECS [18] = '{
        '{1'b1, 32'h10, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h00, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h10, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h00, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h1C, 1'b0, 1'b0, 1'b1},
        '{1'b0, 32'h00, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h0C, 1'b0, 1'b0, 1'b1},
        '{1'b0, 32'h00, 1'b1, 1'b0, 1'b0},
        '{1'b1, 32'h28, 1'b0, 1'b0, 1'b1},
        '{1'b0, 32'h00, 1'b1, 1'b0, 1'b0},
        '{1'b1, 32'h20, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h00, 1'b1, 1'b0, 1'b0},
        '{1'b1, 32'h30, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h00, 1'b1, 1'b0, 1'b0},
        '{1'b1, 32'h10, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h00, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h14, 1'b0, 1'b0, 1'b0},
        '{1'b0, 32'h00, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic cyc(input logic cbr, input logic mp, input logic [31:0] pc,
                       input logic rv, input logic rt, input logic [31:0] rpc,
                       input logic [31:0] tgt);
        @(negedge clk);
        fetch_is_cbr = cbr; fetch_mispred = mp; fetch_pc = pc;
        res_valid = rv; res_taken = rt; res_pc = rpc; res_target = tgt;
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // Reset state, R2
        cyc(1'b1, 1'b0, 32'h3C, 1'b0, 1'b0, 0, 0);
        chk("R2 stall in reset", fetch_stall, 0);
        chk("R2 redirect in reset", redirect_valid, 0);
        @(negedge clk);
        fetch_is_cbr = 1'b0;
        rst_n = 1'b1;
        #2;
        chk("R2 stall after reset", fetch_stall, 0);
        chk("R2 redirect after reset", redirect_valid, 0);

        // Vector walk: R1 index hash, R4 saturation, R5 history shift
        for (int i = 0; i < 18; i++) begin
            cyc(VECS[i].cbr, 1'b0, VECS[i].pc, VECS[i].rv, VECS[i].rt, 0, 0);
            chk($sformatf("R1/R4/R5 vector %0d pred", i), pred_taken, VECS[i].exp_pred);
            chk($sformatf("R3 vector %0d stall", i), fetch_stall, 0);
        end

        // R6: each resolution trains the index saved at its lookup (history 0011)
        cyc(1'b1, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R6 first lookup", pred_taken, 0);
        cyc(1'b1, 1'b0, 32'h04, 1'b0, 1'b0, 0, 0);
        chk("R6 second lookup", pred_taken, 0);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b1, 0, 0);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b1, 0, 0);
        cyc(1'b1, 1'b0, 32'h34, 1'b0, 1'b0, 0, 0);
        chk("R6 saved index trained", pred_taken, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b1, 0, 0);

        // R7/R8/R9/R10: mispredict, taken resolution
        cyc(1'b1, 1'b1, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R7 no stall on mispredict fetch", fetch_stall, 0);
        cyc(1'b1, 1'b0, 32'h34, 1'b0, 1'b0, 0, 0);
        chk("R7 stall after mispredict", fetch_stall, 1);
        chk("R10 lookup ignored while held", pred_taken, 0);
        chk("R8 no early redirect", redirect_valid, 0);
        cyc(1'b0, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R7 still stalled", fetch_stall, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b1, 32'h100, 32'h400);
        chk("R7 stalled on resolve cycle", fetch_stall, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R8 redirect valid", redirect_valid, 1);
        chk("R8 redirect target", redirect_pc, 32'h400);
        chk("R8 stall during redirect", fetch_stall, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R9 fetch resumes", fetch_stall, 0);
        chk("R9 redirect dropped", redirect_valid, 0);

        // R8: not-taken resolution gives fall-through
        cyc(1'b1, 1'b1, 32'h00, 1'b0, 1'b0, 0, 0);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b0, 32'h200, 32'h800);
        chk("R7 stalled until not-taken resolve", fetch_stall, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R8 fall-through redirect", redirect_pc, 32'h204);
        chk("R8 redirect valid not-taken", redirect_valid, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R9 resume after not-taken", fetch_stall, 0);

        // R6/R10: resolution with nothing pending leaves history 1110
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b1, 0, 0);
        cyc(1'b1, 1'b0, 32'h30, 1'b0, 1'b0, 0, 0);
        chk("R6 spurious resolve ignored", pred_taken, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b1, 0, 0);
        cyc(1'b1, 1'b0, 32'h3C, 1'b0, 1'b0, 0, 0);
        chk("R4 upper saturation", pred_taken, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b1, 0, 0);

        // R11: pending list full
        for (int k = 0; k < PD; k++) begin
            cyc(1'b1, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
            chk($sformatf("R11 no stall at fill %0d", k), fetch_stall, 0);
        end
        cyc(1'b1, 1'b0, 32'h3C, 1'b0, 1'b0, 0, 0);
        chk("R11 stall when full", fetch_stall, 1);
        chk("R11 lookup ignored when full", pred_taken, 0);
        cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b0, 0, 0);
        chk("R11 still full before pop", fetch_stall, 1);
        cyc(1'b0, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R11 stall released", fetch_stall, 0);
        for (int k = 0; k < PD - 1; k++) cyc(1'b0, 1'b0, 32'h00, 1'b1, 1'b0, 0, 0);
        cyc(1'b0, 1'b0, 32'h00, 1'b0, 1'b0, 0, 0);
        chk("R11 drained", fetch_stall, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule